// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the transfer address and transfer length state of a group of DMA channels. Each channel owns a base address, a base count, a current address and a current count, all sixteen bits wide. A host reaches them over an 8-bit register bus. Because the registers are twice as wide as the bus, every access goes through a single byte pointer shared by all channels. The pointer selects the low or the high half and flips after each access. A companion control block can force the pointer to a known state through clear and set strobes.

Reads do not return a stored register. They return the live position of the channel. For an address read this is the current address moved by the bytes already transferred, in the direction set by that channel's decrement mode bit. For a count read it is the number of units still to go. A transfer engine reports its progress through a synchronous port that overwrites one channel's current count.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every base and current register is 0, the byte pointer is 0 (low byte) and the read data output is 0.
- R2: The register index is bits [3:0] of the port after a right shift by WORD_MODE. Index bits [3:1] select the channel and bit 0 selects the count (1) or the address (0). The index must stay below 2*NCH.
- R3: Each read or write strobe flips the byte pointer, unless a clear or set strobe is active in the same cycle. Pointer value 0 selects bits [7:0] and value 1 selects bits [15:8]. With no strobe at all the pointer holds.
- R4: A write while the pointer is 0 replaces bits [7:0] of the selected base register. It leaves bits [15:8] and both current registers of that channel unchanged.
- R5: A write while the pointer is 1 replaces bits [15:8] of the selected base register. In the same cycle it sets that channel's current count to 0 and its current address to the updated base address.
- R6: A count read yields base count minus current count, modulo 2^16.
- R7: An address read yields current address plus current count when the channel's decrement bit is 0, and current address minus current count when that bit is 1, modulo 2^16.
- R8: A read places the byte chosen by the pointer on the read data output one clock after the strobe. The output holds its value in every cycle without a read. A read and a write in the same cycle act as a write only.
- R9: bptr_clr forces the pointer to 0 and bptr_set forces it to 1. Clear wins over set, and both win over the flip caused by an access.
- R10: A progress write loads prog_count into the current count of channel prog_ch. It is dropped when a bus write hits the same channel in the same cycle. A progress write to a different channel still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_port | input | 4+WORD_MODE | Register port offset |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| bptr_clr | input | 1 | Force byte pointer to low |
| bptr_set | input | 1 | Force byte pointer to high |
| bptr | output | 1 | Current byte pointer state |
| chan_dec | input | NCH | Per-channel decrement mode bit |
| prog_we | input | 1 | Progress update strobe |
| prog_ch | input | clog2(NCH) | Channel of the progress update |
| prog_count | input | 16 | New current count value |

## Verification
The properties treat the strobes as clean single-cycle pulses sampled on the clock. They do not check the register contents directly. That is left to the bench, which only ever drives port indices inside the decoded range of 2*NCH entries, so no aliased channel is reached. The rule that the read data holds assumes a cycle without a read leaves the output untouched, even when a write or a progress update occurs in that cycle. The stimulus deliberately overlaps writes with progress updates and uses both pointer strobes together, so the priority rules are exercised.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 4,
  parameter int WORD_MODE = 0,
  localparam int PORT_W = 4 + WORD_MODE,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PORT_W-1:0] bus_port,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              bptr_clr,
  input  logic              bptr_set,
  output logic              bptr,
  input  logic [NCH-1:0]    chan_dec,
  input  logic              prog_we,
  input  logic [CHW-1:0]    prog_ch,
  input  logic [15:0]       prog_count
);

  logic [15:0] base_a [NCH];
  logic [15:0] base_c [NCH];
  logic [15:0] cur_a  [NCH];
  logic [15:0] cur_c  [NCH];

  wire [3:0]     idx    = bus_port[WORD_MODE +: 4];
  wire [CHW-1:0] sel    = idx[CHW:1];
  wire           is_cnt = idx[0];
  wire           rd_en  = bus_rd & ~bus_wr;

  logic [15:0] live;
  always_comb begin
    if (is_cnt)
      live = base_c[sel] - cur_c[sel];
    else if (chan_dec[sel])
      live = cur_a[sel] - cur_c[sel];
    else
      live = cur_a[sel] + cur_c[sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0;
        base_c[i] <= '0;
        cur_a[i]  <= '0;
        cur_c[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (bus_wr && sel == CHW'(i)) begin
          if (!bptr) begin
            if (is_cnt) base_c[i][7:0] <= bus_wdata;
            else        base_a[i][7:0] <= bus_wdata;
          end else begin
            if (is_cnt) begin
              base_c[i][15:8] <= bus_wdata;
              cur_a[i]        <= base_a[i];
            end else begin
              base_a[i][15:8] <= bus_wdata;
              cur_a[i]        <= {bus_wdata, base_a[i][7:0]};
            end
            cur_c[i] <= '0;
          end
        end else if (prog_we && prog_ch == CHW'(i)) begin
          cur_c[i] <= prog_count;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             bptr <= 1'b0;
    else if (bptr_clr)      bptr <= 1'b0;
    else if (bptr_set)      bptr <= 1'b1;
    else if (bus_wr | bus_rd) bptr <= ~bptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= bptr ? live[15:8] : live[7:0];
  end

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bptr_clr,
  input logic       bptr_set,
  input logic       bptr,
  input logic [7:0] bus_rdata
);

  AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) && !bptr_clr && !bptr_set |=> bptr != $past(bptr)); // R3

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr && !bus_rd && !bptr_clr && !bptr_set |=> $stable(bptr)); // R3

  AST_PTR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    bptr_clr |=> !bptr); // R9

  AST_PTR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bptr_set && !bptr_clr |=> bptr); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R8

endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bptr_clr(bptr_clr), .bptr_set(bptr_set), .bptr(bptr), .bus_rdata(bus_rdata)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  logic clk = 0;
  always #10 clk = ~clk;

  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0, bptr_clr = 0, bptr_set = 0, prog_we = 0;
  logic [3:0]  bus_port = 0;
  logic [7:0]  bus_wdata = 0;
  logic [3:0]  chan_dec = 0;
  logic [1:0]  prog_ch = 0;
  logic [15:0] prog_count = 0;
  logic [7:0]  bus_rdata;
  logic        bptr;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bptr_clr(bptr_clr), .bptr_set(bptr_set), .bptr(bptr),
    .chan_dec(chan_dec), .prog_we(prog_we), .prog_ch(prog_ch),
    .prog_count(prog_count)
  );

  int checks = 0, errors = 0;
  string tag = "R1";

  // behavioural reference model
  int m_ba[4], m_bc[4], m_ca[4], m_cc[4];
  int m_ptr, m_rd;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; end
    m_ptr = 0; m_rd = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int ch, v, nptr;
      bit wrote;
      ch = bus_port[2:1];
      wrote = 0;
      if (bus_wr) begin
        wrote = 1;
        if (m_ptr == 0) begin
          if (bus_port[0]) m_bc[ch] = (m_bc[ch] & 16'hff00) | bus_wdata;
          else             m_ba[ch] = (m_ba[ch] & 16'hff00) | bus_wdata;
        end else begin
          if (bus_port[0]) m_bc[ch] = (m_bc[ch] & 16'h00ff) | (bus_wdata << 8);
          else             m_ba[ch] = (m_ba[ch] & 16'h00ff) | (bus_wdata << 8);
          m_cc[ch] = 0;
          m_ca[ch] = m_ba[ch];
        end
      end else if (bus_rd) begin
        if (bus_port[0]) v = m_bc[ch] - m_cc[ch];
        else if (chan_dec[ch]) v = m_ca[ch] - m_cc[ch];
        else v = m_ca[ch] + m_cc[ch];
        v = v & 16'hffff;
        m_rd = m_ptr ? (v >> 8) : (v & 8'hff);
      end
      if (prog_we && !(wrote && int'(prog_ch) == ch)) m_cc[prog_ch] = prog_count;
      nptr = m_ptr;
      if (bptr_clr) nptr = 0;
      else if (bptr_set) nptr = 1;
      else if (bus_wr || bus_rd) nptr = 1 - m_ptr;
      m_ptr = nptr;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (bus_rdata !== 8'(m_rd) || bptr !== 1'(m_ptr)) begin
        errors++;
        $display("FAIL %s model: rdata=%h bptr=%b expected rdata=%h bptr=%0d",
                 tag, bus_rdata, bptr, m_rd[7:0], m_ptr);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bptr_clr = 0; bptr_set = 0; prog_we = 0;
  endtask

  task automatic wr(input logic [3:0] p, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_port = p; bus_wdata = d;
    bptr_clr = 0; bptr_set = 0; prog_we = 0;
  endtask

  task automatic rd16(input logic [3:0] p, output int v);
    int lo;
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_port = p; bptr_clr = 1; bptr_set = 0; prog_we = 0;
    @(negedge clk);
    bus_rd = 0; bptr_clr = 0;
    @(negedge clk);
    bus_rd = 1;
    @(negedge clk);
    bus_rd = 0; lo = bus_rdata;
    @(negedge clk);
    bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    v = (bus_rdata << 8) | lo;
  endtask

  task automatic ptr_clr();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bptr_clr = 1; bptr_set = 0; prog_we = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 bptr", bptr, 0);
    check("R1 rdata", bus_rdata, 0);
    rd16(4'h1, v); check("R1 count ch0", v, 0);

    // R4: low byte write leaves current address untouched
    tag = "R4";
    ptr_clr();
    wr(4'h4, 8'hCD);
    idle();
    check("R3 ptr after one write", bptr, 1);
    rd16(4'h4, v); check("R4 addr ch2 live", v, 0);

    // R5: high byte write reloads current registers
    tag = "R5";
    ptr_clr();
    wr(4'h4, 8'hCD);
    wr(4'h4, 8'hAB);
    idle();
    rd16(4'h4, v); check("R5 addr ch2 reload", v, 16'hABCD);

    // R6 / R2: count of channel 2 at index 5
    tag = "R6";
    ptr_clr();
    wr(4'h5, 8'h00);
    wr(4'h5, 8'h01);
    idle();
    rd16(4'h5, v); check("R6 count ch2 fresh", v, 16'h0100);
    @(negedge clk); prog_we = 1; prog_ch = 2; prog_count = 16'h0005;
    idle();
    rd16(4'h5, v); check("R6 count ch2 after progress", v, 16'h00FB);

    // R7: address direction
    tag = "R7";
    rd16(4'h4, v); check("R7 addr increment", v, 16'hABD2);
    chan_dec = 4'b0100;
    rd16(4'h4, v); check("R7 addr decrement", v, 16'hABC8);
    chan_dec = 4'b0000;

    // R10: progress suppressed by write to same channel, not by other channel
    tag = "R10";
    ptr_clr();
    @(negedge clk);
    bptr_clr = 0; bus_wr = 1; bus_port = 4'h5; bus_wdata = 8'h00;
    prog_we = 1; prog_ch = 2; prog_count = 16'h0009;
    idle();
    rd16(4'h5, v); check("R10 same channel suppressed", v, 16'h00FB);
    ptr_clr();
    @(negedge clk);
    bptr_clr = 0; bus_wr = 1; bus_port = 4'h5; bus_wdata = 8'h00;
    prog_we = 1; prog_ch = 3; prog_count = 16'h0002;
    idle();
    rd16(4'h7, v); check("R10 other channel applied", v, 16'hFFFE);

    // R2: channel 1 and 3 are distinct slots
    tag = "R2";
    ptr_clr();
    wr(4'h2, 8'h11); wr(4'h2, 8'h22);
    wr(4'h6, 8'h33); wr(4'h6, 8'h44);
    idle();
    rd16(4'h2, v); check("R2 ch1 addr", v, 16'h2211);
    rd16(4'h6, v); check("R2 ch3 addr", v, 16'h4433);

    // R9: set strobe gives high byte first; clear beats set
    tag = "R9";
    @(negedge clk); bptr_set = 1;
    idle();
    check("R9 set", bptr, 1);
    @(negedge clk); bus_rd = 1; bus_port = 4'h2;
    idle();
    check("R9 high byte first", bus_rdata, 8'h22);
    @(negedge clk); bptr_clr = 1; bptr_set = 1; bus_rd = 1;
    idle();
    check("R9 clear wins", bptr, 0);

    // R8: output holds without read, write-and-read acts as write
    tag = "R8";
    v = bus_rdata;
    @(negedge clk); bus_wr = 1; bus_rd = 1; bus_port = 4'h0; bus_wdata = 8'h77;
    idle();
    repeat (3) @(negedge clk);
    check("R8 rdata held", bus_rdata, v);

    // R3: mixed traffic against the model
    tag = "R3";
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      bus_wr = (k % 3 == 0); bus_rd = (k % 3 == 1);
      bus_port = 4'((k * 5) % 8); bus_wdata = 8'(k * 37);
      prog_we = (k % 4 == 2); prog_ch = 2'(k); prog_count = 16'(k * 91);
      chan_dec = 4'(k);
      bptr_clr = (k % 11 == 0); bptr_set = (k % 13 == 5);
    end
    idle();
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule